// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one burst command into the column addresses the memory array should see, one per clock. A controller loads a 9-bit start column with a one-cycle start strobe, together with a burst length code and a wrap order, sequential or interleaved. From the next cycle on, the block presents one column per beat until the burst ends, and it flags the final beat of a finite burst so that the controller can plan its next command.

A burst ends when its length runs out, when a terminate pulse arrives, or when a new start pulse replaces it. A new start can come on any cycle, including the final beat or a terminate cycle. The start then wins and the new burst begins from its own column and configuration. In full-page mode the burst walks through all 512 columns and keeps going, wrapping at the top, until it is stopped. Length and order are captured only at start, so the mode decoding upstream may change while a burst runs.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `colAddr` is 0 and `burstActive` and `lastBeat` are low.
- R2: In the cycle after `startValid` is sampled high at a clock edge, `burstActive` is high and `colAddr` equals the start column that was sampled.
- R3: For a sequential burst of length L (code 0,1,2,3 meaning L = 1,2,4,8), beat k shows the low log2(L) bits equal to (start + k) mod L and the upper bits equal to those of the start column.
- R4: For an interleaved burst of length L (codes 0 to 3), beat k shows the low log2(L) bits equal to the start's low bits XOR k, and the upper bits equal to those of the start column.
- R5: A finite burst of length L keeps `burstActive` high for exactly L cycles, `lastBeat` is high only on the L-th of them, and `burstActive` is low in the cycle after.
- R6: A length code of 4 to 7 with sequential order gives a full-page burst: beat k shows (start + k) mod 512, so 511 is followed by 0, `lastBeat` never rises, and the burst runs until it is terminated or restarted.
- R7: A length code of 4 to 7 with interleaved order behaves exactly as an interleaved burst of length 8.
- R8: A `terminate` pulse sampled while a burst runs, with no start in the same cycle, makes `burstActive` low in the next cycle and leaves `colAddr` at the beat it showed; a `terminate` pulse while idle changes nothing.
- R9: A start pulse sampled during a burst, on any beat and even together with `terminate`, restarts from the new start column with the new length and order in the next cycle.
- R10: Changes on `burstLen` and `burstInterleave` during a burst, with no start pulse, have no effect on that burst.
- R11: While no burst runs, `colAddr` holds the last column it showed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| startValid | input | 1 | Start a new burst in this cycle |
| startCol | input | 9 | First column of the new burst |
| burstLen | input | 3 | Length code: 0..3 give 1,2,4,8 beats, 4..7 give full page |
| burstInterleave | input | 1 | 1 selects interleaved order, 0 sequential |
| terminate | input | 1 | End the running burst |
| colAddr | output | 9 | Column address of the current beat |
| burstActive | output | 1 | A burst beat is presented in this cycle |
| lastBeat | output | 1 | This is the final beat of a finite burst |

## Verification
Every result is due exactly one cycle after the edge that samples its cause: a start shows its first column in the next cycle, each further beat comes one cycle later, and a terminate or the end of length clears `burstActive` one cycle after the sampling edge. The bench drives inputs and reads outputs on the falling edge, so the value read half a cycle after an edge is the one that edge produced. A sweep over every start column, every finite length and both orders checks each beat against arithmetic in the bench. Directed runs cover full-page wrap, restarts, terminates and configuration changes during a burst.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  // Strobes from the burst control to the address datapath.
  typedef struct packed {
    logic load;     // capture a new start column, zero the beat count
    logic advance;  // move to the next beat
    logic stop;     // burst ends at this edge
  } colStrobe_t;

endpackage

// File: rtl/burst_col_ctrl.sv
module burst_col_ctrl
  import burst_col_pkg::*;
#(
  parameter int COL_W   = 9,
  parameter int LEN_W   = 3,
  parameter int MAX_LOG = 3   // longest finite burst is 2**MAX_LOG beats
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic [LEN_W-1:0] burstLen,
  input  logic             burstInterleave,
  input  logic             terminate,
  input  logic [COL_W-1:0] beatCount,
  output colStrobe_t       strobe,
  output logic [COL_W-1:0] cfgMask,
  output logic             cfgInterleave,
  output logic             burstActive,
  output logic             lastBeat
);

  localparam logic [COL_W-1:0] ONE       = COL_W'(1);
  localparam logic [COL_W-1:0] IL_MASK   = (ONE << MAX_LOG) - ONE;
  localparam logic [LEN_W-1:0] LAST_CODE = LEN_W'(MAX_LOG);

  logic             activeReg;
  logic             fullPageReg;
  logic             interleaveReg;
  logic [COL_W-1:0] maskReg;
  logic [COL_W-1:0] newMask;
  logic             newFullPage;
  logic             finalBeat;

  // Mask of the address bits that walk during the new burst.
  always_comb begin
    newFullPage = 1'b0;
    if (burstLen <= LAST_CODE) begin
      newMask = (ONE << burstLen) - ONE;
    end else if (burstInterleave) begin
      newMask = IL_MASK;
    end else begin
      newMask     = '1;
      newFullPage = 1'b1;
    end
  end

  assign finalBeat = activeReg && !fullPageReg && (beatCount == maskReg);

  always_comb begin
    strobe.load    = startValid;
    strobe.stop    = !startValid && activeReg && (terminate || finalBeat);
    strobe.advance = !startValid && activeReg && !terminate && !finalBeat;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeReg     <= 1'b0;
      fullPageReg   <= 1'b0;
      interleaveReg <= 1'b0;
      maskReg       <= '0;
    end else if (strobe.load) begin
      activeReg     <= 1'b1;
      fullPageReg   <= newFullPage;
      interleaveReg <= burstInterleave;
      maskReg       <= newMask;
    end else if (strobe.stop) begin
      activeReg <= 1'b0;
    end
  end

  assign cfgMask       = maskReg;
  assign cfgInterleave = interleaveReg;
  assign burstActive   = activeReg;
  assign lastBeat      = finalBeat;

  // R2: a start always yields an active beat next cycle
  p_start_active_r2: assert property (@(posedge clk) disable iff (!rstN)
    startValid |=> burstActive);

  // R5: the final beat is followed by an idle cycle unless restarted
  p_last_ends_r5: assert property (@(posedge clk) disable iff (!rstN)
    (lastBeat && !startValid) |=> !burstActive);

  // R8: terminate without a start ends the burst
  p_term_ends_r8: assert property (@(posedge clk) disable iff (!rstN)
    (terminate && !startValid) |=> !burstActive);

  // R7: interleave with a page code is clamped to the longest finite length
  p_il_clamp_r7: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && burstInterleave && (burstLen > LAST_CODE)) |=> (cfgMask == IL_MASK));

  // R10: configuration only moves on a start
  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !startValid |=> ($stable(cfgMask) && $stable(cfgInterleave)));

endmodule

// File: rtl/burst_col_dp.sv
module burst_col_dp
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [COL_W-1:0] startCol,
  input  colStrobe_t       strobe,
  input  logic [COL_W-1:0] cfgMask,
  input  logic             cfgInterleave,
  output logic [COL_W-1:0] beatCount,
  output logic [COL_W-1:0] colAddr
);

  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  logic [COL_W-1:0] baseReg;
  logic [COL_W-1:0] beatReg;
  logic [COL_W-1:0] seqWalk;
  logic [COL_W-1:0] ilWalk;
  logic [COL_W-1:0] walked;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseReg <= '0;
      beatReg <= '0;
    end else if (strobe.load) begin
      baseReg <= startCol;
      beatReg <= '0;
    end else if (strobe.advance) begin
      beatReg <= beatReg + ONE;
    end
  end

  assign seqWalk = baseReg + beatReg;
  assign ilWalk  = baseReg ^ beatReg;
  assign walked  = cfgInterleave ? ilWalk : seqWalk;

  // Per bit: walking bits come from the wrap order, the rest from the start.
  for (genvar b = 0; b < COL_W; b++) begin : g_bitSel
    assign colAddr[b] = cfgMask[b] ? walked[b] : baseReg[b];
  end

  assign beatCount = beatReg;

  // R2: first beat shows the sampled start column
  p_load_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (colAddr == $past(startCol)));

  // R3: bits outside the wrap block never move during a burst
  p_upper_fixed_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> (((colAddr ^ $past(colAddr)) & ~cfgMask) == '0));

  // R3: sequential steps add one inside the wrap block
  p_seq_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !cfgInterleave) |=> (((colAddr - $past(colAddr)) & cfgMask) == ONE));

  // R11: without load or advance the column holds
  p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.advance) |=> $stable(colAddr));

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W   = 9,
  parameter int LEN_W   = 3,
  parameter int MAX_LOG = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic [COL_W-1:0] startCol,
  input  logic [LEN_W-1:0] burstLen,
  input  logic             burstInterleave,
  input  logic             terminate,
  output logic [COL_W-1:0] colAddr,
  output logic             burstActive,
  output logic             lastBeat
);

  colStrobe_t       strobe;
  logic [COL_W-1:0] cfgMask;
  logic             cfgInterleave;
  logic [COL_W-1:0] beatCount;

  burst_col_ctrl #(
    .COL_W  (COL_W),
    .LEN_W  (LEN_W),
    .MAX_LOG(MAX_LOG)
  ) ctrl_i (
    .clk            (clk),
    .rstN           (rstN),
    .startValid     (startValid),
    .burstLen       (burstLen),
    .burstInterleave(burstInterleave),
    .terminate      (terminate),
    .beatCount      (beatCount),
    .strobe         (strobe),
    .cfgMask        (cfgMask),
    .cfgInterleave  (cfgInterleave),
    .burstActive    (burstActive),
    .lastBeat       (lastBeat)
  );

  burst_col_dp #(
    .COL_W(COL_W)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .startCol     (startCol),
    .strobe       (strobe),
    .cfgMask      (cfgMask),
    .cfgInterleave(cfgInterleave),
    .beatCount    (beatCount),
    .colAddr      (colAddr)
  );

  // R5: the final-beat flag only appears on an active beat
  p_last_active_r5: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |-> burstActive);

endmodule

// File: tb/burst_col_gen_tb_top.sv
`timescale 1ns/1ps
module burst_col_gen_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startValid = 1'b0;
  logic [8:0] startCol = '0;
  logic [2:0] burstLen = '0;
  logic       burstInterleave = 1'b0;
  logic       terminate = 1'b0;
  logic [8:0] colAddr;
  logic       burstActive;
  logic       lastBeat;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  burst_col_gen dut_i (
    .clk            (clk),
    .rstN           (rstN),
    .startValid     (startValid),
    .startCol       (startCol),
    .burstLen       (burstLen),
    .burstInterleave(burstInterleave),
    .terminate      (terminate),
    .colAddr        (colAddr),
    .burstActive    (burstActive),
    .lastBeat       (lastBeat)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int maskOf(input int code, input bit il);
    if (code < 4) return (1 << code) - 1;
    return il ? 7 : 511;
  endfunction

  function automatic int expCol(input int s, input int m, input bit il, input int k);
    int low;
    low = il ? ((s ^ k) & m) : ((s + k) & m);
    return (s & ~m & 511) | low;
  endfunction

  // Called on a falling edge: present a start, return on the falling edge
  // where beat 0 is visible.
  task automatic issueStart(input int s, input int code, input bit il, input bit term);
    startValid      = 1'b1;
    startCol        = 9'(s);
    burstLen        = 3'(code);
    burstInterleave = il;
    terminate       = term;
    @(negedge clk);
    startValid = 1'b0;
    terminate  = 1'b0;
  endtask

  task automatic checkBeat(input string req, input int s, input int code, input bit il, input int k);
    int m;
    bit fp;
    m  = maskOf(code, il);
    fp = (code >= 4) && !il;
    check(req, int'(colAddr), expCol(s, m, il, k));
    check(req, int'(burstActive), 1);
    check(req, int'(lastBeat), (!fp && k == m) ? 1 : 0);
  endtask

  task automatic fullBurst(input string req, input int s, input int code, input bit il);
    int len;
    len = maskOf(code, il) + 1;
    issueStart(s, code, il, 1'b0);
    for (int k = 0; k < len; k++) begin
      checkBeat(req, s, code, il, k);
      @(negedge clk);
    end
    check("R5 end", int'(burstActive), 0);
    check("R5 end", int'(lastBeat), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int held;
    // R1 reset state
    #1;
    check("R1", int'(colAddr), 0);
    check("R1", int'(burstActive), 0);
    check("R1", int'(lastBeat), 0);
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", int'(burstActive), 0);

    // R2 R3 R4 R5: sweep every start, finite length and order
    for (int s = 0; s < 512; s++) begin
      for (int code = 0; code < 4; code++) begin
        for (int il = 0; il < 2; il++) begin
          fullBurst(il != 0 ? "R4 interleave" : "R3 sequential", s, code, il[0]);
        end
      end
    end

    // R7: page code with interleave acts as length 8
    for (int code = 4; code < 8; code++) begin
      fullBurst("R7", 'h1f5, code, 1'b1);
    end

    // R6: full-page sequential from 509 wraps and keeps going
    issueStart(509, 7, 1'b0, 1'b0);
    for (int k = 0; k < 600; k++) begin
      check("R6", int'(colAddr), (509 + k) % 512);
      check("R6", int'(lastBeat), 0);
      check("R6", int'(burstActive), 1);
      if (k < 599) @(negedge clk);
    end
    held = (509 + 599) % 512;
    terminate = 1'b1;
    @(negedge clk);
    terminate = 1'b0;
    check("R8 full page stop", int'(burstActive), 0);
    check("R8 full page stop", int'(colAddr), held);

    // R8: terminate mid-burst on beat 3, then R11 hold while idle
    issueStart('h0a3, 3, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) @(negedge clk);
    checkBeat("R8", 'h0a3, 3, 1'b0, 3);
    terminate = 1'b1;
    @(negedge clk);
    terminate = 1'b0;
    check("R8", int'(burstActive), 0);
    check("R8", int'(colAddr), expCol('h0a3, 7, 1'b0, 3));
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R11", int'(colAddr), expCol('h0a3, 7, 1'b0, 3));
      check("R11", int'(burstActive), 0);
    end
    // R8: terminate while idle has no effect
    terminate = 1'b1;
    @(negedge clk);
    terminate = 1'b0;
    check("R8 idle", int'(burstActive), 0);
    check("R8 idle", int'(colAddr), expCol('h0a3, 7, 1'b0, 3));
    check("R8 idle", int'(lastBeat), 0);

    // R9: restart on beat 1 together with terminate
    issueStart('h010, 3, 1'b0, 1'b0);
    @(negedge clk);
    checkBeat("R9", 'h010, 3, 1'b0, 1);
    issueStart('h02a, 2, 1'b1, 1'b1);
    for (int k = 0; k < 4; k++) begin
      checkBeat("R9 restart", 'h02a, 2, 1'b1, k);
      @(negedge clk);
    end
    check("R9 restart end", int'(burstActive), 0);

    // R9: restart on the final beat
    issueStart('h155, 1, 1'b0, 1'b0);
    @(negedge clk);
    checkBeat("R9", 'h155, 1, 1'b0, 1);
    issueStart('h1fe, 7, 1'b0, 1'b0);
    for (int k = 0; k < 5; k++) begin
      checkBeat("R9 last-beat restart", 'h1fe, 7, 1'b0, k);
      @(negedge clk);
    end
    terminate = 1'b1;
    @(negedge clk);
    terminate = 1'b0;

    // R10: config changes mid-burst are ignored
    issueStart('h0c6, 3, 1'b1, 1'b0);
    for (int k = 0; k < 8; k++) begin
      checkBeat("R10", 'h0c6, 3, 1'b1, k);
      burstLen        = 3'(k % 8);
      burstInterleave = k[0];
      @(negedge clk);
    end
    check("R10 end", int'(burstActive), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule